// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

This block is one DMA channel. It moves one data unit from a source address to a destination address each time it receives a request pulse. A unit is either a byte or a 16-bit word. A byte-wide control register sets the unit size, the run mode, the stepping of each pointer and the arming of the channel. The same register holds a latched request flag.

Each serviced request produces one read on a simple synchronous memory bus, then one write. Both bus accesses wait for a ready handshake. After the write completes, the engine steps the pointers and decrements a unit counter.

When the counter runs out, a one-cycle completion pulse is raised. In single mode the channel then disarms itself. In repeat mode the counter and both pointers are restored to the values software last wrote, and the channel keeps running. Software reaches the control, source, destination and count registers through a small register port with a registered read.

Top module: `dma_channel`

## Requirements
- R1: After a synchronous reset the control, source, destination and count registers read 0, `bus_rd`, `bus_wr` and `done` are low.
- R2: Control bit 0 picks the unit: 1 means byte (`bus_byte` high, forward step 1, written data is the low byte of the read data with the upper bits zero), 0 means 16-bit word (`bus_byte` low, forward step 2, data passed whole).
- R3: Control bit 2 is the request flag. A `req_in` pulse sets it. A register write with bit 2 at 0 clears it. A write with bit 2 at 1 leaves it unchanged. A request arriving in the same cycle as a clear wins.
- R4: Control bit 3 arms the channel (1 = armed). A request that arrives while the channel is disarmed only sets the flag and starts no bus access. Arming later services the latched flag.
- R5: Each serviced request performs exactly one read at the source pointer, then one write of that data at the destination pointer. The request flag is cleared when the write completes.
- R6: Control bit 4 (source) and bit 5 (destination) select stepping. 0 keeps the pointer fixed. 1 advances it by the unit step after each unit.
- R7: A control write with bits 4 and 5 both 1 leaves both step bits at their previous values, while the other bits are written normally. The two step bits are never both 1.
- R8: Control bits 7:6 always read 0, whatever is written to them.
- R9: The count register drops by one per unit. The unit that brings it from 1 to 0 raises `done` for exactly one cycle. In single mode (control bit 1 = 0) the same unit clears the arm bit. A count of 0 is treated as the full counter range.
- R10: In repeat mode (control bit 1 = 1), the terminal unit raises `done`. It also restores the count, source and destination to the values last written by software, and the channel stays armed.
- R11: `bus_rd` and `bus_wr` are never high together. Each stays high with a stable `bus_addr` until a clock edge where `bus_ready` is high.
- R12: Register index 0 is control, 1 is source, 2 is destination and 3 is count. `reg_rdata` shows the register selected by `reg_addr` one clock after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index (0 control, 1 source, 2 destination, 3 count) |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Registered read data for the index of the previous cycle |
| req_in | input | 1 | Transfer request pulse |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| bus_byte | output | 1 | Access size, 1 = byte, 0 = 16-bit |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data, valid with bus_ready during a read |
| bus_ready | input | 1 | Access completes at a clock edge where this is high |
| done | output | 1 | One-cycle pulse when the counter reaches zero |

## Verification
The assertions assume that `req_in` and register writes are the only things that change the channel's state. They also assume a slave that eventually raises `bus_ready`, so every unit takes at least three cycles and two `done` pulses can never be adjacent. The bench slave raises ready only while a strobe is high, after a programmed number of wait cycles (zero to two). Requests are issued one at a time, and the bench waits for the write of each unit before the next. Software rewrites the control register only while the bus is idle.

// File: rtl/dma_pkg.sv
package dma_pkg;

  // Control register layout, bit 5 down to bit 0.
  typedef struct packed {
    logic dst_fwd;
    logic src_fwd;
    logic enable;
    logic req_flag;
    logic repeat_md;
    logic byte_md;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_WRITE = 2'd2
  } seq_state_t;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_SRC  = 2'd1;
  localparam logic [1:0] SEL_DST  = 2'd2;
  localparam logic [1:0] SEL_CNT  = 2'd3;

endpackage

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
  import dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              req_in,
  input  logic              unit_done,
  input  logic              terminal,
  output ctrl_t             ctrl
);

  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl;
    if (wr_en) begin
      ctrl_d.byte_md   = wdata[0];
      ctrl_d.repeat_md = wdata[1];
      if (!wdata[2]) ctrl_d.req_flag = 1'b0;
      ctrl_d.enable    = wdata[3];
      if (!(wdata[4] && wdata[5])) begin
        ctrl_d.src_fwd = wdata[4];
        ctrl_d.dst_fwd = wdata[5];
      end
    end
    if (unit_done) begin
      ctrl_d.req_flag = 1'b0;
      if (terminal && !ctrl.repeat_md) ctrl_d.enable = 1'b0;
    end
    if (req_in) ctrl_d.req_flag = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else     ctrl <= ctrl_d;
  end

endmodule

// File: rtl/dma_ptr.sv
module dma_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          advance,
  input  logic          fwd,
  input  logic [AW-1:0] step,
  input  logic          reload,
  output logic [AW-1:0] cur
);

  logic [AW-1:0] base;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= '0;
      base <= '0;
    end else if (load) begin
      cur  <= load_val;
      base <= load_val;
    end else if (advance) begin
      if (reload)   cur <= base;
      else if (fwd) cur <= cur + step;
    end
  end

endmodule

// File: rtl/dma_counter.sv
module dma_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  input  logic          reload,
  output logic [CW-1:0] cnt,
  output logic          terminal
);

  localparam logic [CW-1:0] LAST = CW'(1);

  logic [CW-1:0] base;

  assign terminal = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      base <= '0;
    end else if (load) begin
      cnt  <= load_val;
      base <= load_val;
    end else if (dec) begin
      if (reload) cnt <= base;
      else        cnt <= cnt - LAST;
    end
  end

endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          byte_md,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_byte,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          unit_done
);

  localparam int BW = 8;

  seq_state_t state;

  assign unit_done = (state == SEQ_WRITE) && bus_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_byte  <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      case (state)
        SEQ_IDLE: if (go) begin
          state    <= SEQ_READ;
          bus_rd   <= 1'b1;
          bus_addr <= src;
          bus_byte <= byte_md;
        end
        SEQ_READ: if (bus_ready) begin
          state    <= SEQ_WRITE;
          bus_rd   <= 1'b0;
          bus_wr   <= 1'b1;
          bus_addr <= dst;
          if (bus_byte) bus_wdata <= {{(DW-BW){1'b0}}, bus_rdata[BW-1:0]};
          else          bus_wdata <= bus_rdata;
        end
        SEQ_WRITE: if (bus_ready) begin
          state  <= SEQ_IDLE;
          bus_wr <= 1'b0;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic          req_in,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_byte,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic          done
);

  localparam int NPTR = 2;

  ctrl_t         ctrl_q;
  logic          unit_done;
  logic          terminal;
  logic          reload;
  logic [CW-1:0] cnt;
  logic [AW-1:0] step;
  logic [AW-1:0] ptr_cur [NPTR];

  assign step   = ctrl_q.byte_md ? AW'(1) : AW'(2);
  assign reload = terminal && ctrl_q.repeat_md;

  dma_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_we && (reg_addr == SEL_CTRL)),
    .wdata     (reg_wdata[CTRL_W-1:0]),
    .req_in    (req_in),
    .unit_done (unit_done),
    .terminal  (terminal),
    .ctrl      (ctrl_q)
  );

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    localparam logic [1:0] SEL = (g == 0) ? SEL_SRC : SEL_DST;
    logic fwd;
    assign fwd = (g == 0) ? ctrl_q.src_fwd : ctrl_q.dst_fwd;
    dma_ptr #(.AW(AW)) u_ptr (
      .clk      (clk),
      .rst      (rst),
      .load     (reg_we && (reg_addr == SEL)),
      .load_val (reg_wdata[AW-1:0]),
      .advance  (unit_done),
      .fwd      (fwd),
      .step     (step),
      .reload   (reload),
      .cur      (ptr_cur[g])
    );
  end

  dma_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (reg_we && (reg_addr == SEL_CNT)),
    .load_val (reg_wdata[CW-1:0]),
    .dec      (unit_done),
    .reload   (reload),
    .cnt      (cnt),
    .terminal (terminal)
  );

  dma_bus_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .go        (ctrl_q.enable && ctrl_q.req_flag),
    .byte_md   (ctrl_q.byte_md),
    .src       (ptr_cur[0]),
    .dst       (ptr_cur[1]),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_byte  (bus_byte),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .unit_done (unit_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      reg_rdata <= '0;
    end else begin
      done <= unit_done && terminal;
      case (reg_addr)
        SEL_CTRL: reg_rdata <= RW'(ctrl_q);
        SEL_SRC:  reg_rdata <= RW'(ptr_cur[0]);
        SEL_DST:  reg_rdata <= RW'(ptr_cur[1]);
        default:  reg_rdata <= RW'(cnt);
      endcase
    end
  end

endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [5:0]    ctrl_bits,
  input logic          req_in,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_ready,
  input logic [AW-1:0] bus_addr,
  input logic          done
);

  // ctrl_bits: 0 byte, 1 repeat, 2 flag, 3 arm, 4 src step, 5 dst step
  AST_STEP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ctrl_bits[4] && ctrl_bits[5])); // R7

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr)); // R11

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr))); // R11

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_ready) |=> (bus_wr && $stable(bus_addr))); // R11

  AST_START_ARMED: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rd) |-> $past(ctrl_bits[3])); // R4

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    req_in |=> ctrl_bits[2]); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_SINGLE_DISARM: assert property (@(posedge clk) disable iff (rst)
    (done && !ctrl_bits[1]) |-> !ctrl_bits[3]); // R9

endmodule

bind dma_channel dma_channel_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctrl_bits (ctrl_q),
  .req_in    (req_in),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_ready (bus_ready),
  .bus_addr  (bus_addr),
  .done      (done)
);

// File: tb/tb_dma_channel.sv
module tb_dma_channel;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        req_in = 1'b0;
  logic        bus_rd, bus_wr, bus_byte, bus_ready, done;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;

  always #4 clk = ~clk;

  dma_channel dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_in(req_in),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_byte(bus_byte),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .done(done)
  );

  function automatic logic [15:0] pat(input logic [15:0] a);
    return (a * 16'd7) + 16'h1357;
  endfunction

  // Bus slave and activity log
  int          wait_cfg = 0;
  int          wcnt = 0;
  int          nrd = 0, nwr = 0, ndone = 0;
  logic [15:0] last_rd = '0, last_wr = '0, last_wd = '0;
  logic        last_byte = 1'b0;

  assign bus_ready = (bus_rd || bus_wr) && (wcnt >= wait_cfg);
  assign bus_rdata = pat(bus_addr);

  always @(posedge clk) begin
    if ((bus_rd || bus_wr) && !bus_ready) wcnt <= wcnt + 1;
    else                                  wcnt <= 0;
    if (bus_rd && bus_ready) begin nrd <= nrd + 1; last_rd <= bus_addr; end
    if (bus_wr && bus_ready) begin
      nwr <= nwr + 1; last_wr <= bus_addr; last_wd <= bus_wdata; last_byte <= bus_byte;
    end
    if (done) ndone <= ndone + 1;
  end

  int errors = 0;
  int checks = 0;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    #1 d = reg_rdata;
  endtask

  task automatic pulse_req();
    @(negedge clk);
    req_in = 1'b1;
    @(negedge clk);
    req_in = 1'b0;
  endtask

  task automatic run_unit();
    int start = nwr;
    pulse_req();
    for (int k = 0; k < 100 && nwr == start; k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  typedef struct packed {
    logic [7:0]  c_ctrl;
    logic [15:0] c_src;
    logic [15:0] c_dst;
    logic [15:0] c_cnt;
    logic [7:0]  n_req;
    logic [15:0] x_src;
    logic [15:0] x_dst;
    logic [15:0] x_cnt;
    logic [7:0]  x_ctrl;
    logic [15:0] x_rd;
    logic [15:0] x_wr;
    logic [7:0]  x_done;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{8'h18, 16'h0100, 16'h0200, 16'd3, 8'd3, 16'h0106, 16'h0200, 16'd0, 8'h10, 16'h0104, 16'h0200, 8'd1},
    '{8'h29, 16'h0300, 16'h0400, 16'd4, 8'd2, 16'h0300, 16'h0402, 16'd2, 8'h29, 16'h0300, 16'h0401, 8'd0},
    '{8'h2A, 16'h0500, 16'h0600, 16'd2, 8'd3, 16'h0500, 16'h0602, 16'd1, 8'h2A, 16'h0500, 16'h0600, 8'd1},
    '{8'h1B, 16'h0700, 16'h0800, 16'd1, 8'd2, 16'h0700, 16'h0800, 16'd1, 8'h1B, 16'h0700, 16'h0800, 8'd2},
    '{8'h08, 16'h0900, 16'h0A00, 16'd1, 8'd1, 16'h0900, 16'h0A00, 16'd0, 8'h00, 16'h0900, 16'h0A00, 8'd1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] pv;
    logic [15:0] exp_wd;
    int rd0, wr0, dn0;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R12 register map
    #1;
    check("R1 bus_rd", {15'b0, bus_rd}, 16'h0);
    check("R1 bus_wr", {15'b0, bus_wr}, 16'h0);
    check("R1 done", {15'b0, done}, 16'h0);
    rd_reg(2'd0, v); check("R1 ctrl", v, 16'h0000);
    rd_reg(2'd1, v); check("R1 src", v, 16'h0000);
    rd_reg(2'd3, v); check("R1 cnt", v, 16'h0000);
    wr_reg(2'd2, 16'hBEEF);
    rd_reg(2'd2, v); check("R12 dst index", v, 16'hBEEF);

    // Vector table
    for (int i = 0; i < 5; i++) begin
      wait_cfg = i % 3;
      wr_reg(2'd1, VECS[i].c_src);
      wr_reg(2'd2, VECS[i].c_dst);
      wr_reg(2'd3, VECS[i].c_cnt);
      wr_reg(2'd0, {8'h00, VECS[i].c_ctrl});
      rd0 = nrd; wr0 = nwr; dn0 = ndone;
      for (int r = 0; r < int'(VECS[i].n_req); r++) run_unit();
      check("R5 reads per request", 16'(nrd - rd0), 16'(VECS[i].n_req));
      check("R11 writes match reads", 16'(nwr - wr0), 16'(nrd - rd0));
      check("R6 last read addr", last_rd, VECS[i].x_rd);
      check("R6 last write addr", last_wr, VECS[i].x_wr);
      pv = pat(VECS[i].x_rd);
      exp_wd = VECS[i].c_ctrl[0] ? {8'h00, pv[7:0]} : pv;
      check("R2 write data", last_wd, exp_wd);
      check("R2 bus_byte", {15'b0, last_byte}, {15'b0, VECS[i].c_ctrl[0]});
      check("R9 R10 done pulses", 16'(ndone - dn0), 16'(VECS[i].x_done));
      rd_reg(2'd1, v); check("R6 R10 src final", v, VECS[i].x_src);
      rd_reg(2'd2, v); check("R6 R10 dst final", v, VECS[i].x_dst);
      rd_reg(2'd3, v); check("R9 R10 cnt final", v, VECS[i].x_cnt);
      rd_reg(2'd0, v); check("R9 R10 ctrl final", v, {8'h00, VECS[i].x_ctrl});
    end

    wait_cfg = 1;
    // R8 unused bits
    wr_reg(2'd0, 16'h00C1);
    rd_reg(2'd0, v); check("R8 upper bits zero", v, 16'h0001);

    // R7 illegal step combination keeps old step bits
    wr_reg(2'd0, 16'h0010);
    wr_reg(2'd0, 16'h0031);
    rd_reg(2'd0, v); check("R7 both-forward rejected", v, 16'h0011);

    // R3 and R4 with a disarmed channel
    wr_reg(2'd0, 16'h0000);
    rd0 = nrd;
    pulse_req();
    repeat (10) @(negedge clk);
    check("R4 no access while disarmed", 16'(nrd - rd0), 16'h0);
    rd_reg(2'd0, v); check("R3 flag set by request", v, 16'h0004);
    wr_reg(2'd0, 16'h0000);
    rd_reg(2'd0, v); check("R3 flag cleared by write 0", v, 16'h0000);
    wr_reg(2'd0, 16'h0004);
    rd_reg(2'd0, v); check("R3 write 1 ignored", v, 16'h0000);

    // R4 latched request serviced after arming
    pulse_req();
    wr_reg(2'd1, 16'h1000);
    wr_reg(2'd2, 16'h2000);
    wr_reg(2'd3, 16'd5);
    wr0 = nwr;
    wr_reg(2'd0, 16'h000C);
    repeat (12) @(negedge clk);
    check("R4 latched request serviced", 16'(nwr - wr0), 16'h1);
    check("R5 write addr", last_wr, 16'h2000);
    rd_reg(2'd0, v); check("R5 flag cleared after unit", v, 16'h0008);
    rd_reg(2'd3, v); check("R9 count decremented", v, 16'd4);

    // R4 disarming stops the channel
    wr_reg(2'd0, 16'h0000);
    wr0 = nwr;
    pulse_req();
    repeat (12) @(negedge clk);
    check("R4 disarmed ignores request", 16'(nwr - wr0), 16'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule